// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a software-serviced watchdog. It has a small bank of 32-bit registers on a simple synchronous write port with byte enables and a combinational read port. Software programs a timeout in ticks and writes the reload field, which loads the live counter. It then clears the halt control bit, and the counter starts to count down. A parameterised prescaler divides the system clock into ticks. In silicon one tick is 0.6 s, so a timeout of N seconds is programmed as N*10/6 ticks. In simulation the divider can be made short.

When the counter expires, the first-stage timeout flag is set and the counter reloads itself. Software is expected to service the timer and clear that flag before the next expiry. If the flag is still set when the counter expires again, the second-stage flag is set. A reset request is then raised, unless the no-reboot input holds it back. All status flags are write-one-to-clear. The lock control bit is sticky until a hardware reset. A write to either of the two data byte registers records a software event flag.

The register map has five dword addresses, selected by `bus_addr`:

| Address | Bits 31:24 | Bits 23:16 | Bits 15:0 |
|---|---|---|---|
| 0 | data-out byte | data-in byte | reload / live count |
| 1 | second status word (bits 31:16) | | first status word |
| 2 | second control word (bits 31:16) | | first control word |
| 3 | software IRQ-generation byte | watchdog-count byte | message-2 byte (15:8) and message-1 byte (7:0) |
| 4 | zero | zero | timer value (the field is TMR_W bits wide) |

Top module: `wdt_two_stage`

## Requirements
- R1: Reset defaults, as read through the address map above, are as follows. Address 0 reads 0. Address 1 reads 0. Address 2 reads 0x0008_0000. Address 3 reads 0x0300_0000. Address 4 reads 0x0000_0004. `reset_req` is 0.
- R2: A write to address 0 with either of byte enables 0 or 1 set loads the counter, whatever the data. The value loaded is the timer field, and a timer field of 0 loads 1. Address 0 bits 15:0 read the live count.
- R3: Bit 11 of address 2 is the halt bit, and while it is 1 the count does not change. Writing 0 to it resumes counting from the held value.
- R4: While the counter is running it drops by one every TICK_DIV clocks, counted from the edge that starts it. On the tick at which it reads 1, bit 3 of address 1 is set and the count reloads from the timer field.
- R5: Writes to the timer register keep only the low TMR_W bits. After 0xFFFF is written, address 4 reads 0x3FF. After 1022 ticks the count reads 1 with no timeout flag, and one more tick sets the flag.
- R6: Status bits change only when a 1 is written to them, which clears them. Writing 0 leaves them unchanged. If hardware sets a bit in the same cycle that software clears it, the set wins.
- R7: An expiry while bit 3 of address 1 is still set sets bit 17 of address 1, the second-stage flag. An expiry after bit 3 has been cleared does not set bit 17.
- R8: At a second-stage event with `no_reboot` low, `reset_req` rises and bit 18 of address 1, the boot-status flag, is set. With `no_reboot` high neither changes. `reset_req` falls when software clears bit 17.
- R9: Bit 12 of address 2 is the lock bit. Once it is written to 1, later writes of 0 leave it at 1.
- R10: A write to byte lane 2 (data-in) or byte lane 3 (data-out) of address 0 stores the byte and sets bit 8 of address 1. It does not reload the counter.
- R11: A counter that reads 0, as it does after reset before any load, does not count and raises no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| no_reboot | input | 1 | When high, a second-stage timeout raises no reset request |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Dword address for reads and writes |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| reset_req | output | 1 | Reset request raised by the second-stage timeout |

## Verification
The bench builds the block with TICK_DIV = 4 and the default TMR_W = 10, so every tick lasts only four clocks. This puts the full-width countdown within about four thousand cycles, so the 1022-tick and 1023-tick boundary of R5 can be checked in full. The short tick also lets the bench step through every count of a ten-tick run, and sample each status flag on the exact clock edge where it should change. Both settings of the reboot gate are then tested against the first-stage and second-stage escalation.

// File: rtl/wdt_pkg.sv
// Package: shared register addresses, bit positions and reset values
// for the two-stage watchdog. Assumes a 32-bit data path and 16-bit
// status and control words packed in pairs.
package wdt_pkg;
    localparam logic [2:0] A_CNT = 3'd0;   // reload/count, data-in, data-out
    localparam logic [2:0] A_STS = 3'd1;   // status pair
    localparam logic [2:0] A_CTL = 3'd2;   // control pair
    localparam logic [2:0] A_MSG = 3'd3;   // message and misc bytes
    localparam logic [2:0] A_TMR = 3'd4;   // timer value

    localparam int S1_TO_BIT   = 3;
    localparam int S1_SWEV_BIT = 8;
    localparam int S2_SEC_BIT  = 1;
    localparam int S2_BOOT_BIT = 2;
    localparam int C1_HALT_BIT = 11;
    localparam int C1_LOCK_BIT = 12;

    localparam logic [15:0] CTL2_RST  = 16'h0008;
    localparam logic [7:0]  SWIRQ_RST = 8'h03;
    localparam logic [15:0] TMR_RST   = 16'h0004;
endpackage

// File: rtl/wdt_tick_gen.sv
// Tick prescaler: emits a one-cycle tick every DIV clocks while run
// is high. It restarts from zero on clear or while stopped, so that
// the first tick comes exactly DIV clocks after a start or a load.
module wdt_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick = run && !clear && (pre_q == LAST);

    // Divider count: wraps at LAST and is held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + PW'(1);
    end
endmodule

// File: rtl/wdt_countdown.sv
// Live countdown: loads on request, decrements on each tick, and on
// the tick where it reads 1 it reports expiry and reloads itself.
// Assumes load_val is already non-zero.
module wdt_countdown #(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             tick,
    output logic [TMR_W-1:0] count,
    output logic             expire
);
    assign expire = tick && (count == TMR_W'(1));

    // Counter register: a load takes priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load || expire)
            count <= load_val;
        else if (tick)
            count <= count - TMR_W'(1);
    end
endmodule

// File: rtl/wdt_regbank.sv
// Register bank: byte-lane writes, write-one-to-clear status, sticky
// lock, second-stage escalation and the gated reset request.
// Assumes TMR_W <= 16 and writes lasting a single cycle.
module wdt_regbank
    import wdt_pkg::*;
#(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [2:0]       addr,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic [TMR_W-1:0] count,
    input  logic             expire,
    input  logic             no_reboot,
    output logic [31:0]      rdata,
    output logic             halt,
    output logic             load,
    output logic [TMR_W-1:0] tmr,
    output logic             flag_to,
    output logic             flag_sec,
    output logic             lock,
    output logic             reset_req
);
    logic [7:0]  din_q, dout_q, msg1_q, msg2_q, wdcnt_q, swirq_q;
    logic [15:0] ctl2_q;
    logic        swev_q, boot_q;
    logic        wr_cnt, wr_sts, wr_ctl, wr_msg, wr_tmr;
    logic [15:0] clr1, clr2, tmr_next;
    logic        sec_evt, swev_set;
    logic [15:0] sts1_rd, sts2_rd, ctl1_rd;

    // Address decode of the write strobe.
    always_comb begin
        wr_cnt = wr && (addr == A_CNT);
        wr_sts = wr && (addr == A_STS);
        wr_ctl = wr && (addr == A_CTL);
        wr_msg = wr && (addr == A_MSG);
        wr_tmr = wr && (addr == A_TMR);
    end

    assign load     = wr_cnt && (be[0] || be[1]);
    assign swev_set = wr_cnt && (be[2] || be[3]);
    assign sec_evt  = expire && flag_to;

    // Per-lane clear masks for the two status words.
    always_comb begin
        clr1 = '0;
        clr2 = '0;
        if (wr_sts) begin
            if (be[0]) clr1[7:0]  = wdata[7:0];
            if (be[1]) clr1[15:8] = wdata[15:8];
            if (be[2]) clr2[7:0]  = wdata[23:16];
            if (be[3]) clr2[15:8] = wdata[31:24];
        end
    end

    // Lane merge for the timer field, trimmed to its width.
    always_comb begin
        tmr_next = 16'(tmr);
        if (be[0]) tmr_next[7:0]  = wdata[7:0];
        if (be[1]) tmr_next[15:8] = wdata[15:8];
    end

    // Status flags: a hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_to   <= 1'b0;
            flag_sec  <= 1'b0;
            boot_q    <= 1'b0;
            swev_q    <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            if (expire)                 flag_to <= 1'b1;
            else if (clr1[S1_TO_BIT])   flag_to <= 1'b0;
            if (swev_set)               swev_q  <= 1'b1;
            else if (clr1[S1_SWEV_BIT]) swev_q  <= 1'b0;
            if (sec_evt)                flag_sec <= 1'b1;
            else if (clr2[S2_SEC_BIT])  flag_sec <= 1'b0;
            if (sec_evt && !no_reboot)  boot_q  <= 1'b1;
            else if (clr2[S2_BOOT_BIT]) boot_q  <= 1'b0;
            if (sec_evt && !no_reboot)  reset_req <= 1'b1;
            else if (clr2[S2_SEC_BIT])  reset_req <= 1'b0;
        end
    end

    // Control, timer and data registers written by byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt    <= 1'b0;
            lock    <= 1'b0;
            ctl2_q  <= CTL2_RST;
            tmr     <= TMR_RST[TMR_W-1:0];
            din_q   <= '0;
            dout_q  <= '0;
            msg1_q  <= '0;
            msg2_q  <= '0;
            wdcnt_q <= '0;
            swirq_q <= SWIRQ_RST;
        end else begin
            if (wr_ctl && be[1]) begin
                halt <= wdata[C1_HALT_BIT];
                lock <= lock | wdata[C1_LOCK_BIT];
            end
            if (wr_ctl && be[2]) ctl2_q[7:0]  <= wdata[23:16];
            if (wr_ctl && be[3]) ctl2_q[15:8] <= wdata[31:24];
            if (wr_tmr)          tmr          <= tmr_next[TMR_W-1:0];
            if (wr_cnt && be[2]) din_q        <= wdata[23:16];
            if (wr_cnt && be[3]) dout_q       <= wdata[31:24];
            if (wr_msg && be[0]) msg1_q       <= wdata[7:0];
            if (wr_msg && be[1]) msg2_q       <= wdata[15:8];
            if (wr_msg && be[2]) wdcnt_q      <= wdata[23:16];
            if (wr_msg && be[3]) swirq_q      <= wdata[31:24];
        end
    end

    // Read words assembled from the individual flags.
    always_comb begin
        sts1_rd = '0;
        sts1_rd[S1_TO_BIT]   = flag_to;
        sts1_rd[S1_SWEV_BIT] = swev_q;
        sts2_rd = '0;
        sts2_rd[S2_SEC_BIT]  = flag_sec;
        sts2_rd[S2_BOOT_BIT] = boot_q;
        ctl1_rd = '0;
        ctl1_rd[C1_HALT_BIT] = halt;
        ctl1_rd[C1_LOCK_BIT] = lock;
    end

    // Read multiplexer over the five dword addresses.
    always_comb begin
        case (addr)
            A_CNT:   rdata = {dout_q, din_q, 16'(count)};
            A_STS:   rdata = {sts2_rd, sts1_rd};
            A_CTL:   rdata = {ctl2_q, ctl1_rd};
            A_MSG:   rdata = {swirq_q, wdcnt_q, msg2_q, msg1_q};
            A_TMR:   rdata = 32'(tmr);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_two_stage.sv
// Top level: joins the prescaler, the countdown and the register bank.
// The counter runs only when it is not halted and holds a non-zero
// value. A timer field of 0 is loaded as 1.
module wdt_two_stage #(
    parameter int TICK_DIV = 4,
    parameter int TMR_W    = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        no_reboot,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        reset_req
);
    logic             tick, expire, load, halt, run;
    logic             flag_to, flag_sec, lock;
    logic [TMR_W-1:0] count, tmr, reload_val;

    assign run        = !halt && (count != '0);
    assign reload_val = (tmr == '0) ? TMR_W'(1) : tmr;

    wdt_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(load), .run(run), .tick(tick)
    );

    wdt_countdown #(.TMR_W(TMR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(reload_val),
        .tick(tick), .count(count), .expire(expire)
    );

    wdt_regbank #(.TMR_W(TMR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .be(bus_be), .wdata(bus_wdata), .count(count), .expire(expire),
        .no_reboot(no_reboot), .rdata(bus_rdata), .halt(halt),
        .load(load), .tmr(tmr), .flag_to(flag_to), .flag_sec(flag_sec),
        .lock(lock), .reset_req(reset_req)
    );
endmodule

// File: rtl/wdt_two_stage_chk.sv
// Checker: temporal properties of the watchdog, attached to the top
// module by the bind below.
module wdt_two_stage_chk #(
    parameter int TMR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             expire,
    input logic             load,
    input logic             halt,
    input logic [TMR_W-1:0] count,
    input logic             flag_to,
    input logic             flag_sec,
    input logic             lock,
    input logic             reset_req,
    input logic             no_reboot
);
    // R4: each tick above 1 takes exactly one off the count
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count > TMR_W'(1)) |=> (count == $past(count) - TMR_W'(1)));
    // R4: an expiry leaves the first-stage flag set
    a_r4_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_to);
    // R3: a halted counter holds its value
    a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> $stable(count));
    // R2: a load never leaves the counter at zero
    a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count != '0));
    // R7: the second-stage flag only follows a pending first-stage flag
    a_r7_second_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_sec) |-> $past(flag_to));
    // R8: a reset request only rises when reboot is allowed
    a_r8_reboot_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> ($past(!no_reboot) && flag_sec));
    // R9: the lock bit never falls while out of reset
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire), .load(load),
    .halt(halt), .count(count), .flag_to(flag_to), .flag_sec(flag_sec),
    .lock(lock), .reset_req(reset_req), .no_reboot(no_reboot)
);

// File: tb/wdt_two_stage_bench.sv
// Directed bench for the two-stage watchdog, one task per scenario.
module wdt_two_stage_bench;
    localparam int DIV = 4;
    localparam logic [2:0] A_CNT = 3'd0, A_STS = 3'd1, A_CTL = 3'd2,
                           A_MSG = 3'd3, A_TMR = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        no_reboot = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        reset_req;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int wr_edge = 0;
    int ref_edge = 0;
    bit done = 1'b0;

    wdt_two_stage #(.TICK_DIV(DIV), .TMR_W(10)) u_wdt_two_stage (
        .clk(clk), .rst_n(rst_n), .no_reboot(no_reboot), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .reset_req(reset_req)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = b; bus_wdata = d;
        @(posedge clk);
        #1;
        wr_edge = cyc;
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic prep(input logic [15:0] tval);
        bwr(A_CTL, 4'b0010, 32'h0000_0800);
        bwr(A_STS, 4'b1111, 32'hFFFF_FFFF);
        bwr(A_TMR, 4'b0011, {16'h0, tval});
        bwr(A_CNT, 4'b0011, 32'h0000_ABCD);
    endtask

    task automatic go();
        bwr(A_CTL, 4'b0010, 32'h0);
        ref_edge = wr_edge;
    endtask

    task automatic t_defaults();
        logic [31:0] d;
        brd(A_CNT, d); chk("R1 cnt", d, 32'h0);
        brd(A_STS, d); chk("R1 sts", d, 32'h0);
        brd(A_CTL, d); chk("R1 ctl", d, 32'h0008_0000);
        brd(A_MSG, d); chk("R1 msg", d, 32'h0300_0000);
        brd(A_TMR, d); chk("R1 tmr", d, 32'h4);
        chk("R1 reset_req", 32'(reset_req), 32'h0);
        wait_to(cyc + 10 * DIV);
        brd(A_STS, d); chk("R11 idle sts", d, 32'h0);
        brd(A_CNT, d); chk("R11 idle cnt", d, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        prep(16'd10);
        brd(A_CNT, d); chk("R2 loaded", d[15:0], 32'd10);
        wait_to(cyc + 2 * DIV);
        brd(A_CNT, d); chk("R3 halted before start", d[15:0], 32'd10);
        go();
        for (int m = 1; m <= 9; m++) begin
            wait_to(ref_edge + m * DIV);
            brd(A_CNT, d); chk("R4 step", d[15:0], 32'(10 - m));
        end
        brd(A_STS, d); chk("R4 no flag at 1", d, 32'h0);
        wait_to(ref_edge + 10 * DIV);
        brd(A_STS, d); chk("R4 flag", d, 32'h8);
        brd(A_CNT, d); chk("R4 reload", d[15:0], 32'd10);
        wait_to(ref_edge + 13 * DIV);
        brd(A_CNT, d); chk("R4 after reload", d[15:0], 32'd7);
        bwr(A_CTL, 4'b0010, 32'h0000_0800);
        wait_to(ref_edge + 20 * DIV);
        brd(A_CNT, d); chk("R3 halt holds", d[15:0], 32'd7);
        go();
        wait_to(ref_edge + 2 * DIV);
        brd(A_CNT, d); chk("R3 resume", d[15:0], 32'd5);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        prep(16'd0);
        brd(A_CNT, d); chk("R2 zero loads one", d[15:0], 32'd1);
        go();
        wait_to(ref_edge + DIV);
        brd(A_STS, d); chk("R4 one-tick timeout", d, 32'h8);
    endtask

    task automatic t_max();
        logic [31:0] d;
        prep(16'hFFFF);
        brd(A_TMR, d); chk("R5 masked", d, 32'h3FF);
        go();
        wait_to(ref_edge + 1022 * DIV);
        brd(A_CNT, d); chk("R5 count 1", d[15:0], 32'd1);
        brd(A_STS, d); chk("R5 no flag yet", d, 32'h0);
        wait_to(ref_edge + 1023 * DIV);
        brd(A_STS, d); chk("R5 flag", d, 32'h8);
    endtask

    task automatic t_second_gated();
        logic [31:0] d;
        no_reboot = 1'b1;
        prep(16'd3);
        go();
        wait_to(ref_edge + 3 * DIV);
        bwr(A_STS, 4'b0001, 32'h0);
        brd(A_STS, d); chk("R6 zero write keeps", d, 32'h8);
        wait_to(ref_edge + 6 * DIV);
        brd(A_STS, d); chk("R7 second flag", d, 32'h0002_0008);
        chk("R8 gated no reset", 32'(reset_req), 32'h0);
        bwr(A_STS, 4'b1111, 32'h0006_0008);
        brd(A_STS, d); chk("R6 one clears", d, 32'h0);
    endtask

    task automatic t_second_reboot();
        logic [31:0] d;
        no_reboot = 1'b0;
        prep(16'd3);
        go();
        wait_to(ref_edge + 3 * DIV);
        bwr(A_STS, 4'b0001, 32'h8);
        brd(A_STS, d); chk("R6 clear first", d, 32'h0);
        wait_to(ref_edge + 6 * DIV);
        brd(A_STS, d); chk("R7 no second after service", d, 32'h8);
        chk("R8 no reset yet", 32'(reset_req), 32'h0);
        wait_to(ref_edge + 9 * DIV);
        brd(A_STS, d); chk("R8 second and boot", d, 32'h0006_0008);
        chk("R8 reset raised", 32'(reset_req), 32'h1);
        bwr(A_STS, 4'b0100, 32'h0002_0000);
        brd(A_STS, d); chk("R8 boot stays", d, 32'h0004_0008);
        chk("R8 reset dropped", 32'(reset_req), 32'h0);
        bwr(A_CTL, 4'b0010, 32'h0000_0800);
        no_reboot = 1'b1;
    endtask

    task automatic t_swev();
        logic [31:0] d;
        logic [31:0] c0;
        bwr(A_STS, 4'b1111, 32'hFFFF_FFFF);
        brd(A_CNT, c0);
        bwr(A_CNT, 4'b0100, 32'h005A_0000);
        brd(A_CNT, d); chk("R10 data-in stored", d[23:16], 32'h5A);
        chk("R10 no reload", d[15:0], c0[15:0]);
        brd(A_STS, d); chk("R10 event", d, 32'h100);
        bwr(A_STS, 4'b0010, 32'h0000_0100);
        brd(A_STS, d); chk("R6 event cleared", d, 32'h0);
        bwr(A_CNT, 4'b1000, 32'hA500_0000);
        brd(A_CNT, d); chk("R10 data-out stored", d[31:24], 32'hA5);
        brd(A_STS, d); chk("R10 event again", d, 32'h100);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        bwr(A_CTL, 4'b0010, 32'h0000_1000);
        brd(A_CTL, d); chk("R9 lock set", d & 32'h1000, 32'h1000);
        bwr(A_CTL, 4'b0010, 32'h0);
        brd(A_CTL, d); chk("R9 lock sticky", d & 32'h1000, 32'h1000);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_defaults();
        t_count();
        t_zero();
        t_max();
        t_second_gated();
        t_second_reboot();
        t_swev();
        t_lock();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end
endmodule